// File: doc/BRIEF.md
# Write-Protected Serial EEPROM Write Slave

This block is the write side of a two-wire serial EEPROM. A system clock oversamples the serial clock and data lines. The block finds start and stop conditions and checks the device select byte against a fixed type code and three strap inputs. It then takes a two-byte memory address and collects one or more data bytes in a page buffer. A stop that falls directly after an acknowledge slot starts a timed internal write cycle. At the end of that cycle the buffered bytes go into an internal byte array.

A write-control input can protect a transaction. It is watched from the start condition until the second address byte has been received. The block drives the data line only through an open-drain pull-down enable. While a write cycle runs, the block ignores the bus completely. A lookup port into the array and the post-write address pointer let the surrounding logic see the stored contents.

Top module: `eeprom_wr_slave`

## Requirements
- R1: A device select byte equal to `1010` in bits 7..4, the chip-enable straps in bits 3..1 and 0 in bit 0 (write) is acknowledged. Any other byte, including one with bit 0 set to 1, gets no acknowledge, and the rest of that transaction is ignored.
- R2: Each of the two address bytes that follow the select byte is acknowledged. The first byte is bits 15..8 of the address and the second is bits 7..0.
- R3: If write control is high at any moment from the start condition to the end of the second address byte, every data byte gets no acknowledge and the array is not changed. If write control is high only after the address, the write is unaffected.
- R4: Unprotected data bytes are each acknowledged. They are stored at the received address and the addresses after it.
- R5: The data address advances only inside its PAGE_BYTES-aligned page. A byte past the end of the page wraps to the start of the same page.
- R6: A write cycle starts only for a stop placed one clock pulse after a data byte's acknowledge slot (the 10th bit position). A stop at any other bit position leaves the array and pointer unchanged and does not raise busy.
- R7: A repeated start discards the buffered data. Only the bytes of a transaction that ends with a valid stop are written.
- R8: After a valid stop, busy_o is high for exactly T_WR system clocks. The array keeps its old contents until busy_o falls.
- R9: While busy_o is high the block never drives the data line. It ignores all bus traffic, including its own select code.
- R10: When the write cycle completes, addr_ptr_o holds the address that follows the last byte written, wrapped within its page. It changes at no other time.
- R11: After reset, busy_o and sda_oe_o are 0, addr_ptr_o is 0 and every array byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for oversampling |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull the data line low when 1 |
| wc_i | input | 1 | Write control, high protects |
| ce_i | input | 3 | Chip-enable straps matched against select bits 3..1 |
| busy_o | output | 1 | Internal write cycle in progress |
| addr_ptr_o | output | 16 | Address counter after the last completed write |
| rd_addr_i | input | MEM_AW | Array lookup address |
| rd_data_o | output | 8 | Array byte at rd_addr_i |

## Verification
Some properties are checked on every clock. The data line stays released while busy, and a commit is never issued for a locked transaction. Every commit is followed by busy, the array holds still while busy, and the pointer moves only when a write cycle completes. Other behaviours appear only in the bench scenarios: which bytes are acknowledged, the address byte order, page wrap, the bit position of the stop, the discard on a repeated start, and the exact span of the write-control window.

// File: rtl/ewr_pkg.sv
package ewr_pkg;
  localparam int ADDR_W = 16;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_DATA
  } phase_e;
endpackage

// File: rtl/ewr_line_sync.sv
module ewr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wc_i,
  output logic sda_o,
  output logic wc_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff, wc_ff;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      wc_ff  <= '0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      wc_ff  <= {wc_ff[STAGES-2:0], wc_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_o      = sda_s;
  assign wc_o       = wc_ff[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // data edge while clock stays high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ewr_protocol.sv
module ewr_protocol
  import ewr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wc_i,
  input  logic              busy_i,
  input  logic [2:0]        ce_i,
  output logic              sda_oe_o,
  output logic              load_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              push_o,
  output logic [7:0]        data_o,
  output logic              discard_o,
  output logic              commit_o,
  output logic              wc_lock_o
);
  phase_e     phase_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q;
  logic [7:0] ahi_q;
  logic       wc_lock_q;
  logic       got_data_q;
  logic       stop_ok;

  // one clock pulse into the frame after an acknowledged data byte
  assign stop_ok   = (phase_q == PH_DATA) && (bit_q == 4'd1) && got_data_q && !wc_lock_q;
  assign wc_lock_o = wc_lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      bit_q      <= '0;
      sh_q       <= '0;
      ahi_q      <= '0;
      wc_lock_q  <= 1'b0;
      got_data_q <= 1'b0;
      sda_oe_o   <= 1'b0;
      load_o     <= 1'b0;
      addr_o     <= '0;
      push_o     <= 1'b0;
      data_o     <= '0;
      discard_o  <= 1'b0;
      commit_o   <= 1'b0;
    end else begin
      load_o    <= 1'b0;
      push_o    <= 1'b0;
      discard_o <= 1'b0;
      commit_o  <= 1'b0;
      if (busy_i) begin
        phase_q  <= PH_IDLE;
        bit_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (start_i) begin
        phase_q    <= PH_DEV;
        bit_q      <= '0;
        sda_oe_o   <= 1'b0;
        wc_lock_q  <= wc_i;
        got_data_q <= 1'b0;
        discard_o  <= 1'b1;
      end else if (stop_i) begin
        phase_q   <= PH_IDLE;
        bit_q     <= '0;
        sda_oe_o  <= 1'b0;
        commit_o  <= stop_ok;
        discard_o <= !stop_ok;
      end else if (phase_q != PH_IDLE) begin
        if (wc_i && phase_q != PH_DATA) wc_lock_q <= 1'b1;
        if (scl_rise_i) begin
          if (bit_q < 4'd8) sh_q <= {sh_q[6:0], sda_i};
          if (bit_q != 4'd9) bit_q <= bit_q + 4'd1;
        end else if (scl_fall_i && bit_q == 4'd8) begin
          unique case (phase_q)
            PH_DEV: begin
              if (sh_q == {DEV_TYPE, ce_i, 1'b0}) begin
                sda_oe_o <= 1'b1;
                phase_q  <= PH_AHI;
              end else begin
                phase_q  <= PH_IDLE;
              end
            end
            PH_AHI: begin
              ahi_q    <= sh_q;
              sda_oe_o <= 1'b1;
              phase_q  <= PH_ALO;
            end
            PH_ALO: begin
              addr_o   <= {ahi_q, sh_q};
              load_o   <= 1'b1;
              sda_oe_o <= 1'b1;
              phase_q  <= PH_DATA;
            end
            PH_DATA: begin
              data_o     <= sh_q;
              push_o     <= !wc_lock_q;
              sda_oe_o   <= !wc_lock_q;
              got_data_q <= got_data_q | !wc_lock_q;
            end
            default: phase_q <= PH_IDLE;
          endcase
        end else if (scl_fall_i && bit_q == 4'd9) begin
          sda_oe_o <= 1'b0;
          bit_q    <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/ewr_page_buf.sv
module ewr_page_buf
  import ewr_pkg::*;
#(
  parameter int PAGE_BYTES = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       load_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       push_i,
  input  logic [7:0]                 data_i,
  output logic [PAGE_BYTES-1:0][7:0] byte_o,
  output logic [PAGE_BYTES-1:0]      valid_o,
  output logic [ADDR_W-1:0]          base_o,
  output logic [ADDR_W-1:0]          next_o
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic [ADDR_W-OFF_W-1:0] page_q;
  logic [OFF_W-1:0]        off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      off_q  <= '0;
    end else if (load_i) begin
      page_q <= addr_i[ADDR_W-1:OFF_W];
      off_q  <= addr_i[OFF_W-1:0];
    end else if (push_i) begin
      off_q  <= off_q + 1'b1;  // wraps inside the page
    end
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    logic [7:0] b_q;
    logic       v_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        b_q <= '0;
        v_q <= 1'b0;
      end else if (clear_i || load_i) begin
        v_q <= 1'b0;
      end else if (push_i && off_q == OFF_W'(i)) begin
        b_q <= data_i;
        v_q <= 1'b1;
      end
    end
    assign byte_o[i]  = b_q;
    assign valid_o[i] = v_q;
  end

  assign base_o = {page_q, {OFF_W{1'b0}}};
  assign next_o = {page_q, off_q};
endmodule

// File: rtl/ewr_array.sv
module ewr_array
  import ewr_pkg::*;
#(
  parameter int MEM_AW     = 8,
  parameter int PAGE_BYTES = 32,
  parameter int T_WR       = 5000
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       commit_i,
  input  logic [PAGE_BYTES-1:0][7:0] byte_i,
  input  logic [PAGE_BYTES-1:0]      valid_i,
  input  logic [ADDR_W-1:0]          base_i,
  input  logic [ADDR_W-1:0]          next_i,
  input  logic [MEM_AW-1:0]          rd_addr_i,
  output logic                       busy_o,
  output logic [ADDR_W-1:0]          ptr_o,
  output logic [7:0]                 rd_data_o
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int CNT_W = $clog2(T_WR + 1);

  logic [7:0]       mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic             done;
  logic [MEM_AW-1:0] slot_addr [PAGE_BYTES];

  assign done = busy_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
      ptr_o  <= '0;
    end else if (!busy_o) begin
      if (commit_i) begin
        busy_o <= 1'b1;
        cnt_q  <= CNT_W'(T_WR - 1);
      end
    end else if (done) begin
      busy_o <= 1'b0;
      ptr_o  <= next_i;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_waddr
    assign slot_addr[i] = MEM_AW'(base_i | ADDR_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int d = 0; d < DEPTH; d++) mem_q[d] <= '0;
    end else if (done) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (valid_i[i]) mem_q[slot_addr[i]] <= byte_i[i];
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/eeprom_wr_slave.sv
module eeprom_wr_slave
  import ewr_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int MEM_AW     = 8,
  parameter int T_WR       = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              wc_i,
  input  logic [2:0]        ce_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_ptr_o,
  input  logic [MEM_AW-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  logic sda_s, wc_s, scl_rise, scl_fall, start_w, stop_w;
  logic load_w, push_w, discard_w, commit_w, wc_lock_w;
  logic [ADDR_W-1:0] addr_w, base_w, next_w;
  logic [7:0] data_w;
  logic [PAGE_BYTES-1:0][7:0] buf_byte;
  logic [PAGE_BYTES-1:0]      buf_valid;

  ewr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i, .wc_i,
    .sda_o(sda_s), .wc_o(wc_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_w), .stop_o(stop_w)
  );

  ewr_protocol u_proto (
    .clk_i, .rst_ni, .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_s),
    .start_i(start_w), .stop_i(stop_w), .wc_i(wc_s), .busy_i(busy_o), .ce_i,
    .sda_oe_o, .load_o(load_w), .addr_o(addr_w), .push_o(push_w), .data_o(data_w),
    .discard_o(discard_w), .commit_o(commit_w), .wc_lock_o(wc_lock_w)
  );

  ewr_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk_i, .rst_ni, .clear_i(discard_w), .load_i(load_w), .addr_i(addr_w),
    .push_i(push_w), .data_i(data_w), .byte_o(buf_byte), .valid_o(buf_valid),
    .base_o(base_w), .next_o(next_w)
  );

  ewr_array #(.MEM_AW(MEM_AW), .PAGE_BYTES(PAGE_BYTES), .T_WR(T_WR)) u_array (
    .clk_i, .rst_ni, .commit_i(commit_w), .byte_i(buf_byte), .valid_i(buf_valid),
    .base_i(base_w), .next_i(next_w), .rd_addr_i, .busy_o, .ptr_o(addr_ptr_o), .rd_data_o
  );
endmodule

module eeprom_wr_slave_chk #(
  parameter int MEM_AW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              sda_oe_o,
  input logic              commit_w,
  input logic              wc_lock_w,
  input logic [15:0]       addr_ptr_o,
  input logic [MEM_AW-1:0] rd_addr_i,
  input logic [7:0]        rd_data_o
);
  assert_quiet_when_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_oe_o);

  assert_no_commit_when_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_w |-> !busy_o);

  assert_locked_never_commits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_w |-> !wc_lock_w);

  assert_commit_starts_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_w |=> busy_o);

  assert_array_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && $stable(rd_addr_i)) |-> $stable(rd_data_o));

  assert_ptr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> $stable(addr_ptr_o));
endmodule

bind eeprom_wr_slave eeprom_wr_slave_chk #(.MEM_AW(MEM_AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .sda_oe_o(sda_oe_o),
  .commit_w(commit_w), .wc_lock_w(wc_lock_w), .addr_ptr_o(addr_ptr_o),
  .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
);

// File: tb/eeprom_wr_slave_tb.sv
module eeprom_wr_slave_tb;
  localparam int T_WR = 400;
  localparam int Q    = 5;
  localparam logic [7:0] DEV = 8'hAA;  // 1010, straps 101, write

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, scl, sda_m, wc;
  logic [2:0] ce;
  logic [7:0] rd_addr;
  logic sda_oe, busy;
  logic [15:0] ptr;
  logic [7:0] rd_data;
  logic sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  eeprom_wr_slave #(.PAGE_BYTES(32), .MEM_AW(8), .T_WR(T_WR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .wc_i(wc), .ce_i(ce), .busy_o(busy), .addr_ptr_o(ptr),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  int checks = 0, fails = 0, busy_cyc = 0;
  bit finished = 0;
  logic [7:0]  mem_m [256];
  logic [15:0] ptr_m = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against model state while a write cycle runs
  always @(negedge clk) begin
    if (rst_n && busy) begin
      busy_cyc++;
      chk(!sda_oe, "R9 line driven while busy", sda_oe, 0);
      chk(ptr == ptr_m, "R10 pointer moved during cycle", ptr, ptr_m);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1; tick(Q); scl = 1; tick(Q); sda_m = 0; tick(Q); scl = 0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 0; tick(Q); scl = 1; tick(Q); sda_m = 1; tick(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1; tick(Q); scl = 1; tick(Q);
    ack = !sda_bus;
    tick(Q); scl = 0; tick(Q);
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 37);
  endfunction

  function automatic void model_apply(input logic [15:0] a, input int n, input logic [7:0] seed);
    logic [4:0] off = a[4:0];
    for (int i = 0; i < n; i++) begin
      mem_m[{a[7:5], off}] = pat(seed, i);
      off = off + 5'd1;
    end
    ptr_m = {a[15:5], off};
  endfunction

  task automatic cmp_mem(input string req);
    int bad = -1;
    for (int a = 0; a < 256; a++) begin
      rd_addr = 8'(a); #1;
      if (bad < 0 && rd_data !== mem_m[a]) bad = a;
    end
    if (bad < 0) chk(1, req, 0, 0);
    else begin
      rd_addr = 8'(bad); #1;
      chk(0, {req, " array byte"}, rd_data, mem_m[bad]);
    end
    tick(1);
  endtask

  task automatic wr_head(input logic [15:0] a, input string req);
    bit ak;
    bus_start;
    send_byte(DEV, ak);     chk(ak, "R1 select ack", ak, 1);
    send_byte(a[15:8], ak); chk(ak, {req, " R2 addr hi ack"}, ak, 1);
    send_byte(a[7:0], ak);  chk(ak, {req, " R2 addr lo ack"}, ak, 1);
  endtask

  task automatic wr_data(input int n, input logic [7:0] seed, input bit exp_ack, input string req);
    bit ak;
    for (int i = 0; i < n; i++) begin
      send_byte(pat(seed, i), ak);
      chk(ak == exp_ack, {req, " data ack"}, ak, exp_ack);
    end
  endtask

  task automatic finish_commit(input logic [15:0] a, input int n, input logic [7:0] seed, input string req);
    busy_cyc = 0;
    bus_stop;
    while (busy) tick(1);
    tick(2);
    chk(busy_cyc == T_WR, "R8 busy length", busy_cyc, T_WR);
    model_apply(a, n, seed);
    cmp_mem(req);
    chk(ptr == ptr_m, "R10 pointer after write", ptr, ptr_m);
  endtask

  task automatic expect_no_write(input string req);
    busy_cyc = 0;
    tick(40);
    chk(busy_cyc == 0, {req, " busy raised"}, busy_cyc, 0);
    cmp_mem(req);
    chk(ptr == ptr_m, {req, " pointer"}, ptr, ptr_m);
  endtask

  initial begin
    bit ak;
    for (int a = 0; a < 256; a++) mem_m[a] = '0;
    rst_n = 0; scl = 1; sda_m = 1; wc = 0; ce = 3'b101; rd_addr = '0;
    tick(5); rst_n = 1; tick(5);

    // R11 reset state
    chk(!busy, "R11 busy", busy, 0);
    chk(!sda_oe, "R11 sda_oe", sda_oe, 0);
    chk(ptr == 16'h0, "R11 pointer", ptr, 0);
    cmp_mem("R11 array clear");

    // R4 byte write; R2 high byte seen in pointer
    wr_head(16'h0112, "R4");
    wr_data(1, 8'hA5, 1, "R4");
    finish_commit(16'h0112, 1, 8'hA5, "R4 byte write");

    // R1 wrong straps
    bus_start;
    send_byte({4'b1010, 3'b011, 1'b0}, ak); chk(!ak, "R1 strap mismatch", ak, 0);
    send_byte(8'h00, ak); chk(!ak, "R1 ignored after mismatch", ak, 0);
    bus_stop;
    expect_no_write("R1 mismatch");

    // R1 read bit set
    bus_start;
    send_byte(8'hAB, ak); chk(!ak, "R1 read bit", ak, 0);
    bus_stop;
    expect_no_write("R1 read bit");

    // R4 page write
    wr_head(16'h0040, "R4");
    wr_data(5, 8'h31, 1, "R4 page");
    finish_commit(16'h0040, 5, 8'h31, "R4 page write");

    // R5 page wrap
    wr_head(16'h007E, "R5");
    wr_data(4, 8'h5C, 1, "R5");
    finish_commit(16'h007E, 4, 8'h5C, "R5 wrap");
    chk(ptr == 16'h0062, "R5 wrapped pointer", ptr, 16'h0062);

    // R3 protect during low address byte only
    bus_start;
    send_byte(DEV, ak); chk(ak, "R1 select ack", ak, 1);
    send_byte(8'h00, ak); chk(ak, "R3 R2 addr hi ack", ak, 1);
    wc = 1;
    send_byte(8'h90, ak); chk(ak, "R3 R2 addr lo ack", ak, 1);
    wc = 0;
    wr_data(2, 8'h77, 0, "R3 locked");
    bus_stop;
    expect_no_write("R3 locked");

    // R3 protect only around the start condition
    wc = 1;
    bus_start;
    wc = 0;
    send_byte(DEV, ak); chk(ak, "R1 select ack", ak, 1);
    send_byte(8'h00, ak); send_byte(8'h91, ak);
    wr_data(1, 8'h19, 0, "R3 start lock");
    bus_stop;
    expect_no_write("R3 start lock");

    // R3 high only after the address: write proceeds
    wr_head(16'h00A0, "R3");
    wc = 1;
    wr_data(2, 8'h42, 1, "R3 late wc");
    wc = 0;
    finish_commit(16'h00A0, 2, 8'h42, "R3 late wc");

    // R6 stop mid-byte
    wr_head(16'h00C0, "R6");
    wr_data(1, 8'hE1, 1, "R6");
    send_bits(8'h00, 3);
    bus_stop;
    expect_no_write("R6 stop mid byte");

    // R7 repeated start discards first part
    wr_head(16'h0050, "R7");
    wr_data(1, 8'h11, 1, "R7");
    wr_head(16'h0060, "R7");
    wr_data(1, 8'h22, 1, "R7");
    finish_commit(16'h0060, 1, 8'h22, "R7 discard");

    // R8/R9 deaf during write cycle
    wr_head(16'h0080, "R9");
    wr_data(2, 8'h66, 1, "R9");
    busy_cyc = 0;
    bus_stop;
    while (!busy) tick(1);
    cmp_mem("R8 array held while busy");
    bus_start;
    send_byte(DEV, ak); chk(!ak, "R9 select ignored while busy", ak, 0);
    bus_stop;
    chk(busy, "R8 still busy", busy, 1);
    while (busy) tick(1);
    tick(2);
    chk(busy_cyc == T_WR, "R8 busy length", busy_cyc, T_WR);
    model_apply(16'h0080, 2, 8'h66);
    cmp_mem("R8 array after cycle");
    chk(ptr == ptr_m, "R10 pointer", ptr, ptr_m);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule